// File: doc/BRIEF.md
# Read Preamble Length Sequencer

This block works out how many bytes a serial-flash read command must receive after its opcode before read data may start, then counts those bytes off. It covers five read classes: single-lane fast read, dual-output, dual-I/O, quad-output and quad-I/O. When a read opcode is decoded, the block picks a vendor profile from the first byte of the identification code. It then adds the address width (3 or 4 bytes) to a vendor-specific number of mode and dummy bytes. Some of those dummy bytes come live from configuration register fields. Dummy clocks are counted as whole bytes.

The command decoder strobes `op_start` with the class, the address width and the current configuration values. The front end strobes `byte_in` once for each preamble byte it receives. When the final byte arrives, `done` pulses for one cycle so that the data phase can begin. Asserting chip-select (`cs_start`) abandons any preamble in flight. Every input that feeds the length is captured at decode, so a configuration write that lands during the preamble does not change the count.

Top module: `rd_preamble_seq`

## Requirements
- R1: The profile is chosen from `id_byte`: 0x20 selects profile M, 0xEF selects profile W, 0x01 selects profile S and 0xC2 selects profile X. Any other value selects the generic profile.
- R2: The loaded length `pre_len` is the address width plus the extra bytes. The address width is 4 when `addr4`=1 and 3 otherwise. `rd_class` encodes 0 fast, 1 dual-output, 2 dual-I/O, 3 quad-output and 4 quad-I/O; values 5 to 7 act as fast.
- R3: Profile W adds 8 for fast, dual-output and quad-output reads, 1 for dual-I/O reads, and 5 for quad-I/O reads (1 mode byte plus 4).
- R4: Profile M adds `vcfg[7:4]` for every class.
- R5: Profile X decodes f=`vcfg[7:6]`. Fast, dual-output and quad-output reads add 6 when f=1 and 8 otherwise. Dual-I/O reads add 6 when f=1, 8 when f=2 and 4 otherwise. Quad-I/O reads add 4 when f=1, 8 when f=2 and 6 otherwise.
- R6: Profile S adds `cr2[3:0]`, plus 1 more mode byte for dual-I/O and quad-I/O reads. `cr2[7:4]` has no effect.
- R7: The generic profile adds nothing beyond the address bytes.
- R8: After `op_start`, `busy` is 1. `done` is a single-cycle pulse that appears on the cycle after the `pre_len`-th `byte_in`, and `busy` falls at the same time. Before that byte, `done` stays 0.
- R9: `cs_start` clears the count: on the next cycle `busy`=0, and later `byte_in` strobes give no `done`.
- R10: `id_byte`, `vcfg`, `cr2`, `rd_class` and `addr4` are sampled only when `op_start` is asserted. Changing them during the preamble changes neither `pre_len` nor the byte on which `done` comes.
- R11: `byte_in` while the block is not busy is ignored and gives no `done`.
- R12: After reset, `busy`=0, `done`=0 and `pre_len`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_start | input | 1 | Chip-select assertion strobe; clears the count |
| op_start | input | 1 | A read opcode has been decoded; load the length |
| rd_class | input | 3 | Read class code |
| addr4 | input | 1 | 1 for 4-byte addressing |
| id_byte | input | 8 | First identification byte |
| vcfg | input | 8 | Volatile configuration register |
| cr2 | input | 8 | Second configuration register |
| byte_in | input | 1 | One preamble byte received |
| busy | output | 1 | Preamble in progress |
| done | output | 1 | Pulse: last preamble byte received |
| pre_len | output | CW | Length loaded at the last decode |

## Verification
The hardest case to reach is a configuration change that arrives while a preamble is still being counted. At the ports this looks the same as a correct design unless the count is checked against the value sampled at decode. The bench loads a profile X read with one dummy field value and switches `vcfg` to a field with a different length right after decode. It then checks that `done` arrives exactly on the originally computed byte. A second scenario drops chip-select halfway through and keeps strobing bytes, to show that the abandoned count never finishes.

// File: rtl/rd_preamble_seq.sv
module rd_preamble_seq #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_start,
  input  logic          op_start,
  input  logic [2:0]    rd_class,
  input  logic          addr4,
  input  logic [7:0]    id_byte,
  input  logic [7:0]    vcfg,
  input  logic [7:0]    cr2,
  input  logic          byte_in,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] pre_len
);
  typedef enum logic [2:0] {PF_GEN, PF_M, PF_W, PF_S, PF_X} prof_t;

  prof_t       prof;
  logic        is_dio, is_qio;
  logic [1:0]  xf;
  logic [4:0]  extra;
  logic [CW-1:0] need, cnt;
  logic        last;

  always_comb begin
    case (id_byte)
      8'h20:   prof = PF_M;
      8'hEF:   prof = PF_W;
      8'h01:   prof = PF_S;
      8'hC2:   prof = PF_X;
      default: prof = PF_GEN;
    endcase
  end

  assign is_dio = (rd_class == 3'd2);
  assign is_qio = (rd_class == 3'd4);
  assign xf     = vcfg[7:6];

  always_comb begin
    extra = '0;
    case (prof)
      PF_W: extra = is_qio ? 5'd5 : (is_dio ? 5'd1 : 5'd8);
      PF_M: extra = {1'b0, vcfg[7:4]};
      PF_S: extra = {1'b0, cr2[3:0]} + {4'd0, (is_dio | is_qio)};
      PF_X:
        if (is_qio)      extra = (xf == 2'd1) ? 5'd4 : (xf == 2'd2) ? 5'd8 : 5'd6;
        else if (is_dio) extra = (xf == 2'd1) ? 5'd6 : (xf == 2'd2) ? 5'd8 : 5'd4;
        else             extra = (xf == 2'd1) ? 5'd6 : 5'd8;
      default: extra = '0;
    endcase
  end

  assign need = CW'(addr4 ? 3'd4 : 3'd3) + CW'(extra);
  assign last = busy && byte_in && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      pre_len <= '0;
    end else if (cs_start) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (op_start) begin
      cnt     <= need;
      pre_len <= need;
      busy    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (busy && byte_in) begin
        cnt <= cnt - CW'(1);
        if (last) busy <= 1'b0;
      end
    end
  end

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> (!busy && !done));
  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start) |=> $stable(pre_len));
  // R11
  idle_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !op_start) |=> !done);
  // R2
  len_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !cs_start) |=> (busy && pre_len >= CW'(3)));
endmodule

// File: tb/rd_preamble_seq_test.sv
module rd_preamble_seq_test;
  localparam int CLK_P = 10;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0, cs_start = 0, op_start = 0, addr4 = 0, byte_in = 0;
  logic [2:0] rd_class = 0;
  logic [7:0] id_byte = 0, vcfg = 0, cr2 = 0;
  logic busy, done;
  logic [CW-1:0] pre_len;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rd_preamble_seq #(.CW(CW)) uut (.clk(clk), .rst_n(rst_n), .cs_start(cs_start),
    .op_start(op_start), .rd_class(rd_class), .addr4(addr4), .id_byte(id_byte),
    .vcfg(vcfg), .cr2(cr2), .byte_in(byte_in), .busy(busy), .done(done),
    .pre_len(pre_len));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] id, input logic [2:0] c,
                                 input logic a4, input logic [7:0] v, input logic [7:0] r2);
    int base = a4 ? 4 : 3;
    bit dio = (c == 2), qio = (c == 4);
    int f = v[7:6];
    case (id)
      8'hEF: return base + (qio ? 5 : dio ? 1 : 8);
      8'h20: return base + int'(v[7:4]);
      8'h01: return base + int'(r2[3:0]) + ((dio || qio) ? 1 : 0);
      8'hC2:
        if (qio)      return base + (f == 1 ? 4 : f == 2 ? 8 : 6);
        else if (dio) return base + (f == 1 ? 6 : f == 2 ? 8 : 4);
        else          return base + (f == 1 ? 6 : 8);
      default: return base;
    endcase
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic issue(input logic [7:0] id, input logic [2:0] c, input logic a4,
                       input logic [7:0] v, input logic [7:0] r2);
    id_byte = id; rd_class = c; addr4 = a4; vcfg = v; cr2 = r2;
    op_start = 1; tick; op_start = 0;
  endtask

  task automatic feed(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      byte_in = 1; tick;
      chk(req, done, 0);
    end
    byte_in = 0;
  endtask

  task automatic t_read(input string req, input logic [7:0] id, input logic [2:0] c,
                        input logic a4, input logic [7:0] v, input logic [7:0] r2);
    int e = exp_len(id, c, a4, v, r2);
    issue(id, c, a4, v, r2);
    chk({req, " len"}, pre_len, e);
    chk({req, " busy"}, busy, 1);
    feed(e - 1, {req, " early"});
    byte_in = 1; tick; byte_in = 0;
    chk({req, " done"}, done, 1);
    chk({req, " busy_drop"}, busy, 0);
    tick;
    chk({req, " pulse"}, done, 0);
  endtask

  task automatic t_reset;
    chk("R12 busy", busy, 0);
    chk("R12 done", done, 0);
    chk("R12 len", pre_len, 0);
  endtask

  task automatic t_cfg_change;
    int e = exp_len(8'hC2, 3'd2, 1'b0, 8'h40, 8'h00);
    issue(8'hC2, 3'd2, 1'b0, 8'h40, 8'h00);
    vcfg = 8'h80; id_byte = 8'h20; rd_class = 3'd0; addr4 = 1;
    chk("R10 len", pre_len, 9);
    feed(e - 1, "R10 early");
    byte_in = 1; tick; byte_in = 0;
    chk("R10 done", done, 1);
    chk("R10 len_after", pre_len, e);
    tick;
  endtask

  task automatic t_cs_abort;
    issue(8'hEF, 3'd0, 1'b0, 8'h00, 8'h00);
    feed(4, "R9 pre");
    cs_start = 1; tick; cs_start = 0;
    chk("R9 busy", busy, 0);
    feed(12, "R9 after_cs");
  endtask

  task automatic t_idle_bytes;
    feed(6, "R11 idle");
    chk("R11 busy", busy, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick; tick;
    t_reset;
    rst_n = 1; tick;
    t_reset;
    t_read("R7", 8'h55, 3'd0, 1'b0, 8'hFF, 8'hFF);
    t_read("R2", 8'h55, 3'd4, 1'b1, 8'h00, 8'h00);
    t_read("R1", 8'h21, 3'd0, 1'b0, 8'hF0, 8'h0F);
    t_read("R3 fast", 8'hEF, 3'd0, 1'b0, 8'h00, 8'h00);
    t_read("R3 dio", 8'hEF, 3'd2, 1'b0, 8'h00, 8'h00);
    t_read("R3 qio", 8'hEF, 3'd4, 1'b1, 8'h00, 8'h00);
    t_read("R4 fast", 8'h20, 3'd0, 1'b0, 8'hA0, 8'h00);
    t_read("R4 dout", 8'h20, 3'd1, 1'b1, 8'hA0, 8'h00);
    t_read("R4 qio", 8'h20, 3'd4, 1'b0, 8'h30, 8'h00);
    t_read("R5 fast1", 8'hC2, 3'd0, 1'b0, 8'h40, 8'h00);
    t_read("R5 fast0", 8'hC2, 3'd3, 1'b0, 8'h00, 8'h00);
    t_read("R5 dio2", 8'hC2, 3'd2, 1'b0, 8'h80, 8'h00);
    t_read("R5 dio0", 8'hC2, 3'd2, 1'b0, 8'hC0, 8'h00);
    t_read("R5 qio1", 8'hC2, 3'd4, 1'b0, 8'h40, 8'h00);
    t_read("R5 qio3", 8'hC2, 3'd4, 1'b1, 8'hC0, 8'h00);
    t_read("R6 fast", 8'h01, 3'd0, 1'b0, 8'h00, 8'h08);
    t_read("R6 dio", 8'h01, 3'd2, 1'b0, 8'h00, 8'h08);
    t_read("R6 qio", 8'h01, 3'd4, 1'b1, 8'h00, 8'hF3);
    t_read("R8 class7", 8'hEF, 3'd7, 1'b0, 8'h00, 8'h00);
    t_cfg_change;
    t_cs_abort;
    t_idle_bytes;
    t_read("R8 after_abort", 8'h01, 3'd4, 1'b0, 8'h00, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule